// File: doc/BRIEF.md
# SMBus Clock-Low Watchdog with Bus Recovery

This block watches the clock line of a two-wire SMBus/I2C bus and enforces two time limits on it. The first limit is on one unbroken low period of SCL. The second limit is on the total SCL low time inside one message, where a START or STOP condition marks the message boundary. Both limits are given in ticks of a fixed prescaler. One tick is `PRESC` kernel clocks, so a 12-bit limit can reach the usual 35 ms and 25 ms values at common kernel clock rates. A single enable gates both checks. With the enable off, the bus behaves as plain I2C and SCL may stay low for any length of time.

When either limit is broken, the block sets a sticky error flag for that limit and takes control of the bus through open-drain pull-down enables. It sends up to `NPULSE` clock pulses to free a slave that is stuck in the middle of a byte. If SDA is seen released at the end of a pulse's high phase, the pulses stop early. The block then sends a STOP condition and raises a one-cycle done strobe. While recovery runs, both timers are held cleared, so the block's own pulses cannot trip them.

Top module: `smb_tmo_guard`

## Requirements
- R1: With the check enabled, the continuous-low error flag is set when SCL has been low for more than `low_limit` ticks. With SCL sampled low at consecutive clock edges starting from a high level, the flag reads 1 after edge (`low_limit`+1)·`PRESC` and reads 0 after one edge fewer.
- R2: Every return of SCL to high clears the continuous-low count and the partial prescaler tick. Low periods that are each shorter than the limit never raise the continuous-low error.
- R3: The cumulative error flag is set when the total SCL-low ticks since the last START or STOP exceed `cum_limit`. The total adds up across separate low periods.
- R4: A START or STOP pulse clears the cumulative total.
- R5: With `tmo_en` low, neither error flag is ever set, however long SCL stays low.
- R6: Each error flag stays at 1 until `err_clr` is pulsed, and then reads 0. If a new error and a clear arrive in the same cycle, the error wins.
- R7: A new error starts recovery. `scl_oe` (1 = pull SCL low) gives pulses of `HALF` cycles low and `HALF` cycles released. If SDA stays low, exactly `NPULSE` pulses are sent.
- R8: SDA is sampled at the end of each pulse's high phase. If it reads 1 there, no further pulses follow and the STOP begins at once.
- R9: The STOP holds SDA low while SCL is pulled low, then releases SCL, then releases SDA while SCL is high. `sda_oe` is asserted only during the STOP. `rec_done` is high for exactly one cycle at the end.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| start_det | input | 1 | One-cycle pulse on a detected START |
| stop_det | input | 1 | One-cycle pulse on a detected STOP |
| tmo_en | input | 1 | Enables both time checks |
| low_limit | input | CW | Continuous-low limit in ticks |
| cum_limit | input | CW | Per-message cumulative low limit in ticks |
| err_clr | input | 1 | Clears both error flags |
| scl_oe | output | 1 | Pull SCL low (open drain) |
| sda_oe | output | 1 | Pull SDA low (open drain) |
| err_low | output | 1 | Sticky continuous-low error |
| err_cum | output | 1 | Sticky cumulative-stretch error |
| rec_busy | output | 1 | Recovery in progress |
| rec_done | output | 1 | One-cycle strobe when recovery finishes |

## Verification
The continuous-low watchdog is driven with a table of hold lengths. It includes lengths just below and exactly at the trip edge, which separate a correct "more than" compare from an off-by-one error. It also includes a long hold with the check disabled, which separates gating from mere delay, and holds well over the limit. Repeated short low bursts show whether the count clears on each rising edge and whether the per-message total still adds up. The same bursts with a START placed between them show whether the total clears at message boundaries. Recovery is run with SDA stuck low, with SDA released partway through, and with SDA high from the start. The number of pulses, the STOP ordering and the width of the done strobe separate the full, early and single-pulse exits.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  // Recovery sequencer phases
  typedef enum logic [2:0] {
    RS_IDLE   = 3'd0,
    RS_CLK_LO = 3'd1,   // recovery pulse, SCL pulled low
    RS_CLK_HI = 3'd2,   // recovery pulse, SCL released
    RS_STP_A  = 3'd3,   // SCL low, SDA low
    RS_STP_B  = 3'd4,   // SCL released, SDA still low
    RS_STP_C  = 3'd5    // both released: STOP formed
  } rec_state_e;

endpackage

// File: rtl/smb_tick_gen.sv
module smb_tick_gen #(
  parameter int PRESC = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] pcnt;

  // Partial ticks are dropped whenever run falls (SCL released).
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign tick = run && (pcnt == LAST);

endmodule

// File: rtl/smb_span_cnt.sv
module smb_span_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          trip
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && cnt != CMAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The tick that would take the count beyond the limit trips.
  assign trip = tick && !clr && (cnt == limit);

endmodule

// File: rtl/smb_bus_recover.sv
module smb_bus_recover
  import smb_tmo_pkg::*;
#(
  parameter int HALF   = 240,
  parameter int NPULSE = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NW = $clog2(NPULSE + 1);
  localparam logic [HW-1:0] PH_LAST  = HW'(HALF - 1);
  localparam logic [NW-1:0] NP_FINAL = NW'(NPULSE - 1);

  rec_state_e    state, nxt;
  logic [HW-1:0] hcnt;
  logic [NW-1:0] npl;
  logic          ph_end;

  assign ph_end = (hcnt == PH_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      RS_IDLE:   if (kick) nxt = RS_CLK_LO;
      RS_CLK_LO: if (ph_end) nxt = RS_CLK_HI;
      RS_CLK_HI: begin
        if (ph_end) begin
          if (sda_in || npl == NP_FINAL) nxt = RS_STP_A;
          else                           nxt = RS_CLK_LO;
        end
      end
      RS_STP_A:  if (ph_end) nxt = RS_STP_B;
      RS_STP_B:  if (ph_end) nxt = RS_STP_C;
      RS_STP_C:  if (ph_end) nxt = RS_IDLE;
      default:   nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RS_IDLE;
      hcnt   <= '0;
      npl    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      if (state != nxt || state == RS_IDLE) hcnt <= '0;
      else                                  hcnt <= hcnt + 1'b1;
      if (state == RS_IDLE)                 npl <= '0;
      else if (state == RS_CLK_HI && ph_end) npl <= npl + 1'b1;
      scl_oe <= (nxt == RS_CLK_LO) || (nxt == RS_STP_A);
      sda_oe <= (nxt == RS_STP_A) || (nxt == RS_STP_B);
      busy   <= (nxt != RS_IDLE);
      done   <= (state == RS_STP_C) && ph_end;
    end
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    npl <= NW'(NPULSE)); // R7
  AST_STOP_SDA_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> scl_oe); // R9
  AST_STOP_SDA_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_oe); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

endmodule

// File: rtl/smb_tmo_guard.sv
module smb_tmo_guard #(
  parameter int CW     = 12,
  parameter int PRESC  = 512,
  parameter int HALF   = 240,
  parameter int NPULSE = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          tmo_en,
  input  logic [CW-1:0] low_limit,
  input  logic [CW-1:0] cum_limit,
  input  logic          err_clr,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          err_low,
  output logic          err_cum,
  output logic          rec_busy,
  output logic          rec_done
);

  logic tick, trip_low, trip_cum, run;
  logic clr_low, clr_cum;

  // Timers are frozen and cleared while disabled or while recovering.
  assign run     = !scl_in && tmo_en && !rec_busy;
  assign clr_low = scl_in || !tmo_en || rec_busy;
  assign clr_cum = start_det || stop_det || !tmo_en || rec_busy;

  smb_tick_gen #(.PRESC(PRESC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  smb_span_cnt #(.CW(CW)) u_low_span (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_low),
    .tick  (tick),
    .limit (low_limit),
    .trip  (trip_low)
  );

  smb_span_cnt #(.CW(CW)) u_cum_span (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_cum),
    .tick  (tick),
    .limit (cum_limit),
    .trip  (trip_cum)
  );

  smb_bus_recover #(.HALF(HALF), .NPULSE(NPULSE)) u_recover (
    .clk    (clk),
    .rst    (rst),
    .kick   (trip_low || trip_cum),
    .sda_in (sda_in),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (rec_busy),
    .done   (rec_done)
  );

  // Sticky flags: a new error outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      err_low <= 1'b0;
      err_cum <= 1'b0;
    end else begin
      if (trip_low)     err_low <= 1'b1;
      else if (err_clr) err_low <= 1'b0;
      if (trip_cum)     err_cum <= 1'b1;
      else if (err_clr) err_cum <= 1'b0;
    end
  end

  AST_LOW_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(err_low) |-> $past(tmo_en)); // R5
  AST_CUM_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(err_cum) |-> $past(tmo_en)); // R5
  AST_LOW_ERR_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(err_low) |-> $past(!scl_in)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_low && !err_clr) |=> err_low); // R6

endmodule

// File: tb/smb_tmo_guard_tb_top.sv
`timescale 1ns/1ps
module smb_tmo_guard_tb_top;

  localparam int CW = 12, PRESC = 4, HALF = 3, NPULSE = 9;
  localparam int LOWL = 10;   // trip edge = (LOWL+1)*PRESC = 44

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic bus_scl = 1'b1, bus_sda = 1'b0, early_hi = 1'b0, early_mode = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0, tmo_en = 1'b1, err_clr = 1'b0;
  logic [CW-1:0] low_limit = CW'(LOWL), cum_limit = CW'(1000);
  logic scl_in, sda_in;
  logic scl_oe, sda_oe, err_low, err_cum, rec_busy, rec_done;

  assign scl_in = bus_scl & ~scl_oe;
  assign sda_in = (bus_sda | early_hi) & ~sda_oe;

  smb_tmo_guard #(.CW(CW), .PRESC(PRESC), .HALF(HALF), .NPULSE(NPULSE)) dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .tmo_en(tmo_en),
    .low_limit(low_limit), .cum_limit(cum_limit), .err_clr(err_clr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .err_low(err_low), .err_cum(err_cum),
    .rec_busy(rec_busy), .rec_done(rec_done));

  int n_chk = 0, n_bad = 0;
  int rises = 0, sda_rises = 0, order_bad = 0, done_cnt = 0, done_run = 0, done_max = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  // Bus observer, sampled away from the active edge
  always @(negedge clk) begin
    if (scl_oe && !prev_scl) rises <= rises + 1;
    if (sda_oe && !prev_sda) begin
      sda_rises <= sda_rises + 1;
      if (!scl_oe) order_bad <= order_bad + 1;
    end
    if (!sda_oe && prev_sda && scl_oe) order_bad <= order_bad + 1;
    if (rec_done) begin
      done_cnt <= done_cnt + 1;
      done_run <= done_run + 1;
      if (done_run + 1 > done_max) done_max <= done_run + 1;
    end else begin
      done_run <= 0;
    end
    early_hi <= early_mode && (early_hi || rises == 3);
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_reset();
    @(negedge clk);
    rises = 0; sda_rises = 0; order_bad = 0; done_cnt = 0; done_max = 0;
  endtask

  task automatic prep();
    @(negedge clk); err_clr = 1'b1; start_det = 1'b1;
    @(negedge clk); err_clr = 1'b0; start_det = 1'b0;
    mon_reset();
  endtask

  task automatic hold_low(int n);
    @(negedge clk) bus_scl = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_scl(int n);
    bus_scl = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (done_cnt == 0 && k < 1000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    check(tag, done_cnt, 1);
  endtask

  // {low clocks, enable, expected err_low}
  localparam int VEC [5][3] = '{
    '{43, 1, 0}, '{44, 1, 1}, '{300, 0, 0}, '{20, 1, 0}, '{60, 1, 1}};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 scl_oe", int'(scl_oe), 0);
    check("R10 sda_oe", int'(sda_oe), 0);
    check("R10 err_low", int'(err_low), 0);
    check("R10 err_cum", int'(err_cum), 0);
    check("R10 rec_busy", int'(rec_busy), 0);
    check("R10 rec_done", int'(rec_done), 0);

    // R1 / R5 table walk; recovery with SDA stuck low checks R7 and R9
    foreach (VEC[i]) begin
      tmo_en = VEC[i][1][0];
      prep();
      hold_low(VEC[i][0]);
      check($sformatf("R1 R5 vec%0d err_low", i), int'(err_low), VEC[i][2]);
      check($sformatf("R5 vec%0d err_cum", i), int'(err_cum), 0);
      release_scl(2);
      if (VEC[i][2] != 0) begin
        wait_done($sformatf("R9 vec%0d done", i));
        check($sformatf("R7 vec%0d scl pulses+stop", i), rises, NPULSE + 1);
        check($sformatf("R9 vec%0d sda_oe once", i), sda_rises, 1);
        check($sformatf("R9 vec%0d stop order", i), order_bad, 0);
        check($sformatf("R9 vec%0d done width", i), done_max, 1);
      end else begin
        check($sformatf("R7 vec%0d no recovery", i), rises, 0);
      end
    end
    tmo_en = 1'b1;

    // R6 sticky flag and clear
    prep();
    hold_low(44);
    release_scl(1);
    wait_done("R6 done");
    repeat (20) @(negedge clk);
    check("R6 err_low held", int'(err_low), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    check("R6 err_low cleared", int'(err_low), 0);

    // R2 repeated sub-limit lows
    prep();
    for (int b = 0; b < 4; b++) begin hold_low(40); release_scl(2); end
    check("R2 err_low", int'(err_low), 0);

    // R3 cumulative over three bursts of 2 ticks, limit 5
    cum_limit = CW'(5);
    prep();
    hold_low(8); release_scl(3);
    hold_low(8); release_scl(3);
    check("R3 cum before", int'(err_cum), 0);
    hold_low(8);
    check("R3 cum after", int'(err_cum), 1);
    check("R3 low untouched", int'(err_low), 0);
    release_scl(1);
    wait_done("R3 done");

    // R4 START between bursts clears the total
    prep();
    hold_low(8); release_scl(3);
    hold_low(8); release_scl(1);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0; @(negedge clk);
    hold_low(8); release_scl(3);
    hold_low(8); release_scl(3);
    check("R4 cum cleared by START", int'(err_cum), 0);
    cum_limit = CW'(1000);

    // R8 SDA released during third pulse
    prep();
    early_mode = 1'b1;
    hold_low(44); release_scl(1);
    wait_done("R8 early done");
    check("R8 early pulses+stop", rises, 4);
    check("R9 early stop order", order_bad, 0);
    early_mode = 1'b0;
    repeat (2) @(negedge clk);

    // R8 SDA high from the first pulse
    bus_sda = 1'b1;
    prep();
    hold_low(44); release_scl(1);
    wait_done("R8 high done");
    check("R8 single pulse+stop", rises, 2);
    check("R9 high sda_oe once", sda_rises, 1);
    bus_sda = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule